// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers interrupt requests for 32 vectors and hands one of them to a CPU. Each vector takes its request from one of three input buses: a fixed-function line, a DMA terminal line or a general routing line, always the bit with the vector's own index. A rising edge on the chosen line latches a pending flag, and that flag holds until it is cleared. Software can also set or clear a pending flag through the configuration write port. Each vector has an enable bit, a priority level from 0 (highest) to 7 (lowest) and a handler address. All of these can be rewritten at run time.

Arbitration runs every cycle over the pending flags. A vector can compete only while it is pending and enabled, and only if its priority is strictly better than the level now in service. Among the vectors that can compete, the best priority wins, and a tie goes to the lowest vector number. The winner's number and handler address are registered and presented together with a request line. When the CPU acknowledges, the presented vector's pending flag is cleared and its priority level is marked in service. When the CPU signals return-from-interrupt, the best in-service level is released, so the service it interrupted resumes. Nesting can reach eight levels.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `irq_req` is 0 and `svc_level` is 8, which means no level is in service. All enables are 0, all priorities are 7, all source selects are 0 and all handler addresses are 0.
- R2: `cfg_src` (op code 2) chooses a vector's request line with `cfg_wdata[1:0]`: 0 selects `req_fixed`, 1 selects `req_dma`, 2 selects `req_route`, and 3 selects no line. A rising edge on the chosen bit sets the pending flag. Edges on the lines that are not chosen have no effect.
- R3: A vector whose enable bit is 0 never causes `irq_req`. Enable is written with op code 0, using `cfg_wdata[0]`. A pending flag stays held while the vector is disabled, and the vector is requested once it is enabled.
- R4: Among the pending, enabled vectors that can compete, the one with the numerically smallest priority is presented on `irq_vec`. A tie goes to the lower vector number.
- R5: While `irq_req` is 1, `irq_addr` equals the handler address last written for vector `irq_vec`. Handler addresses are written with op code 3, using all of `cfg_wdata`.
- R6: Op code 4 sets the pending flag of vector `cfg_idx`, and op code 5 clears it.
- R7: A cycle with `irq_ack` high while `irq_req` is 1 clears the pending flag of the presented vector. From the next cycle, `svc_level` equals that vector's priority.
- R8: A vector is requested only if its priority is strictly smaller than `svc_level`. A vector whose priority equals the active level does not preempt.
- R9: A cycle with `irq_ret` high releases the best in-service level. `svc_level` then shows the next in-service level, or 8 when none is left.
- R10: `irq_req`, `irq_vec` and `irq_addr` change on the clock edge after the edge at which a pending flag or a configuration register changes.
- R11: Priority is written with op code 1, using `cfg_wdata[2:0]`. A rewrite at run time changes which vector wins from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Write operation: 0 enable, 1 priority, 2 source, 3 handler, 4 set pending, 5 clear pending |
| cfg_idx | input | 5 | Target vector |
| cfg_wdata | input | 16 | Write data |
| req_fixed | input | 32 | Fixed-function request lines |
| req_dma | input | 32 | DMA terminal request lines |
| req_route | input | 32 | General routing request lines |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 5 | Presented vector number |
| irq_addr | output | 16 | Handler address of the presented vector |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_ret | input | 1 | CPU returns from the current handler |
| svc_level | output | 4 | Best in-service level, 8 when idle |

## Verification
The assertions assume a well-behaved CPU. It acknowledges only while `irq_req` is high and never in the same cycle as a return. It leaves at least one idle cycle after each acknowledge, so the stale request is not taken twice. It returns only while a level is in service. The assertions also assume that a source select is rewritten only while the request lines are low, so the edge detector sees no false edge. The bench drives all stimulus through tasks that pulse `irq_ack` or `irq_ret` for a single cycle and then wait. It changes a source select before it raises any line, and it pulses each line high for exactly one cycle.

// File: rtl/vic_pkg.sv
// Package: shared operation codes and source-select encodings for the
// vectored interrupt controller. Assumes a 3-bit operation field.
package vic_pkg;
    typedef enum logic [2:0] {
        OP_ENABLE  = 3'd0,
        OP_PRIO    = 3'd1,
        OP_SRCSEL  = 3'd2,
        OP_HANDLER = 3'd3,
        OP_SETPEND = 3'd4,
        OP_CLRPEND = 3'd5
    } vic_op_e;

    localparam logic [1:0] SRC_FIXED = 2'd0;
    localparam logic [1:0] SRC_DMA   = 2'd1;
    localparam logic [1:0] SRC_ROUTE = 2'd2;
    localparam logic [1:0] SRC_NONE  = 2'd3;
endpackage

// File: rtl/vic_reg_bank.sv
// Per-vector configuration storage: enable, priority, source select and
// handler address. It also decodes one-cycle set/clear-pending strobes.
// Assumes NUM_LVL is a power of two; priorities reset to the lowest level.
module vic_reg_bank
    import vic_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 16,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_op,
    input  logic [VEC_W-1:0]                   wr_idx,
    input  logic [ADDR_W-1:0]                  wr_data,
    output logic [NUM_VEC-1:0]                 en_o,
    output logic [NUM_VEC-1:0][PRIO_W-1:0]     prio_o,
    output logic [NUM_VEC-1:0][1:0]            srcsel_o,
    output logic [NUM_VEC-1:0][ADDR_W-1:0]     haddr_o,
    output logic [NUM_VEC-1:0]                 set_o,
    output logic [NUM_VEC-1:0]                 clr_o
);
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic hit;
        assign hit = wr_en && (wr_idx == VEC_W'(g));

        // Hold this vector's configuration fields, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[g]     <= 1'b0;
                prio_o[g]   <= '1;
                srcsel_o[g] <= SRC_FIXED;
                haddr_o[g]  <= '0;
            end else if (hit) begin
                if (wr_op == OP_ENABLE)  en_o[g]     <= wr_data[0];
                if (wr_op == OP_PRIO)    prio_o[g]   <= wr_data[PRIO_W-1:0];
                if (wr_op == OP_SRCSEL)  srcsel_o[g] <= wr_data[1:0];
                if (wr_op == OP_HANDLER) haddr_o[g]  <= wr_data;
            end
        end

        // Decode the software pending strobes for this vector.
        always_comb begin
            set_o[g] = hit && (wr_op == OP_SETPEND);
            clr_o[g] = hit && (wr_op == OP_CLRPEND);
        end
    end
endmodule

// File: rtl/vic_pending.sv
// Pending-flag capture: for each vector it picks the selected request line,
// detects a rising edge on it and holds a pending flag until a clear.
// A set (edge or software) wins over a clear in the same cycle.
// Assumes the source select changes only while the request lines are low.
module vic_pending
    import vic_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_VEC-1:0]      fixed_i,
    input  logic [NUM_VEC-1:0]      dma_i,
    input  logic [NUM_VEC-1:0]      route_i,
    input  logic [NUM_VEC-1:0][1:0] srcsel_i,
    input  logic [NUM_VEC-1:0]      sw_set_i,
    input  logic [NUM_VEC-1:0]      sw_clr_i,
    input  logic [NUM_VEC-1:0]      ack_clr_i,
    output logic [NUM_VEC-1:0]      pend_o
);
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic line;
        logic line_q;
        logic rise;

        // Route the selected request source to this vector.
        always_comb begin
            case (srcsel_i[g])
                SRC_FIXED: line = fixed_i[g];
                SRC_DMA:   line = dma_i[g];
                SRC_ROUTE: line = route_i[g];
                default:   line = 1'b0;
            endcase
        end

        assign rise = line && !line_q;

        // Remember the previous level of the selected line.
        always_ff @(posedge clk) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= line;
        end

        // Set on edge or software request, clear on software or acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                         pend_o[g] <= 1'b0;
            else if (rise || sw_set_i[g])       pend_o[g] <= 1'b1;
            else if (sw_clr_i[g] || ack_clr_i[g]) pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
// Combinational winner selection: among pending, enabled vectors whose
// priority is strictly below the ceiling, the smallest priority value wins,
// with ties going to the lowest index. Pure logic, no state.
module vic_arbiter #(
    parameter int NUM_VEC = 32,
    parameter int PRIO_W  = 3,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int LVL_W  = PRIO_W + 1
) (
    input  logic [NUM_VEC-1:0]             pend_i,
    input  logic [NUM_VEC-1:0]             en_i,
    input  logic [NUM_VEC-1:0][PRIO_W-1:0] prio_i,
    input  logic [LVL_W-1:0]               ceil_i,
    output logic                           found_o,
    output logic [VEC_W-1:0]               win_idx_o,
    output logic [PRIO_W-1:0]              win_prio_o
);
    // Scan upward; only a strictly better priority replaces the holder.
    always_comb begin
        found_o    = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '1;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (pend_i[i] && en_i[i] && (LVL_W'(prio_i[i]) < ceil_i)) begin
                if (!found_o || (prio_i[i] < win_prio_o)) begin
                    found_o    = 1'b1;
                    win_idx_o  = VEC_W'(i);
                    win_prio_o = prio_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/vic_level_tracker.sv
// In-service tracking: one bit per priority level. Acknowledge marks a
// level; return releases the best marked level. The current level is the
// best marked one, or NUM_LVL when none is marked.
module vic_level_tracker #(
    parameter int NUM_LVL = 8,
    localparam int PRIO_W = $clog2(NUM_LVL),
    localparam int LVL_W  = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_lvl_i,
    input  logic              pop_i,
    output logic [LVL_W-1:0]  cur_lvl_o
);
    logic [NUM_LVL-1:0] svc_q;
    logic [NUM_LVL-1:0] pop_mask;
    logic [NUM_LVL-1:0] push_mask;

    // Isolate the best (lowest-numbered) in-service bit for release.
    always_comb begin
        pop_mask  = pop_i  ? (svc_q & (~svc_q + NUM_LVL'(1))) : '0;
        push_mask = push_i ? (NUM_LVL'(1) << push_lvl_i)      : '0;
    end

    // Update the in-service set.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= (svc_q & ~pop_mask) | push_mask;
    end

    // Report the best in-service level.
    always_comb begin
        cur_lvl_o = LVL_W'(NUM_LVL);
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (svc_q[l]) cur_lvl_o = LVL_W'(l);
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top of the vectored priority interrupt controller. Configuration writes
// go to the register bank; the pending flags feed a combinational arbiter
// limited by the in-service level; the winner is registered toward the
// CPU. Assumes the CPU acknowledges only a presented request, leaves one
// idle cycle after it, and never acknowledges and returns in one cycle.
module vec_irq_ctrl #(
    parameter int NUM_VEC = 32,
    parameter int NUM_LVL = 8,
    parameter int ADDR_W  = 16,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int PRIO_W = $clog2(NUM_LVL),
    localparam int LVL_W  = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_op,
    input  logic [VEC_W-1:0]   cfg_idx,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic [NUM_VEC-1:0] req_fixed,
    input  logic [NUM_VEC-1:0] req_dma,
    input  logic [NUM_VEC-1:0] req_route,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [ADDR_W-1:0]  irq_addr,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic [LVL_W-1:0]   svc_level
);
    logic [NUM_VEC-1:0]             en_q;
    logic [NUM_VEC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_VEC-1:0][1:0]        srcsel_q;
    logic [NUM_VEC-1:0][ADDR_W-1:0] haddr_q;
    logic [NUM_VEC-1:0]             sw_set;
    logic [NUM_VEC-1:0]             sw_clr;
    logic [NUM_VEC-1:0]             ack_clr;
    logic [NUM_VEC-1:0]             pend_q;
    logic                           found;
    logic [VEC_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio;
    logic [PRIO_W-1:0]              win_prio_q;
    logic                           ack_fire;

    vic_reg_bank #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_op    (cfg_op),
        .wr_idx   (cfg_idx),
        .wr_data  (cfg_wdata),
        .en_o     (en_q),
        .prio_o   (prio_q),
        .srcsel_o (srcsel_q),
        .haddr_o  (haddr_q),
        .set_o    (sw_set),
        .clr_o    (sw_clr)
    );

    // Acknowledge clears the vector that is being presented.
    always_comb begin
        ack_fire = irq_ack && irq_req;
        ack_clr  = '0;
        if (ack_fire) ack_clr[irq_vec] = 1'b1;
    end

    vic_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .fixed_i   (req_fixed),
        .dma_i     (req_dma),
        .route_i   (req_route),
        .srcsel_i  (srcsel_q),
        .sw_set_i  (sw_set),
        .sw_clr_i  (sw_clr),
        .ack_clr_i (ack_clr),
        .pend_o    (pend_q)
    );

    vic_arbiter #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_arb (
        .pend_i     (pend_q),
        .en_i       (en_q),
        .prio_i     (prio_q),
        .ceil_i     (svc_level),
        .found_o    (found),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    vic_level_tracker #(.NUM_LVL(NUM_LVL)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack_fire),
        .push_lvl_i (win_prio_q),
        .pop_i      (irq_ret),
        .cur_lvl_o  (svc_level)
    );

    // Register the winner toward the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            irq_vec    <= '0;
            irq_addr   <= '0;
            win_prio_q <= '1;
        end else begin
            irq_req    <= found;
            irq_vec    <= win_idx;
            irq_addr   <= haddr_q[win_idx];
            win_prio_q <= win_prio;
        end
    end
endmodule

// File: rtl/vic_checker.sv
// Property checker for the interrupt controller. It keeps one-cycle copies
// of the configuration and pending state, so that each registered output
// can be related to the state it was computed from.
module vic_checker #(
    parameter int NUM_VEC = 32,
    parameter int NUM_LVL = 8,
    parameter int ADDR_W  = 16,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int PRIO_W = $clog2(NUM_LVL),
    localparam int LVL_W  = PRIO_W + 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_VEC-1:0]             en,
    input logic [NUM_VEC-1:0][PRIO_W-1:0] prio,
    input logic [NUM_VEC-1:0][ADDR_W-1:0] haddr,
    input logic [NUM_VEC-1:0]             pend,
    input logic                           irq_req,
    input logic [VEC_W-1:0]               irq_vec,
    input logic [ADDR_W-1:0]              irq_addr,
    input logic                           irq_ack,
    input logic                           irq_ret,
    input logic [LVL_W-1:0]               svc_level
);
    logic [NUM_VEC-1:0]             en_d;
    logic [NUM_VEC-1:0]             pend_d;
    logic [NUM_VEC-1:0][PRIO_W-1:0] prio_d;
    logic [NUM_VEC-1:0][ADDR_W-1:0] addr_d;
    logic [LVL_W-1:0]               lvl_d;
    logic                           better;

    // Keep previous-cycle copies of the state behind the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d   <= '0;
            pend_d <= '0;
            prio_d <= '1;
            addr_d <= '0;
            lvl_d  <= LVL_W'(NUM_LVL);
        end else begin
            en_d   <= en;
            pend_d <= pend;
            prio_d <= prio;
            addr_d <= haddr;
            lvl_d  <= svc_level;
        end
    end

    // Look for any competitor that should have beaten the presented vector.
    always_comb begin
        better = 1'b0;
        for (int j = 0; j < NUM_VEC; j++) begin
            if (en_d[j] && pend_d[j] &&
                ((prio_d[j] < prio_d[irq_vec]) ||
                 ((prio_d[j] == prio_d[irq_vec]) && (VEC_W'(j) < irq_vec))))
                better = 1'b1;
        end
    end

    a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_d[irq_vec] && pend_d[irq_vec]));

    a_r4_best_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !better);

    a_r5_handler_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_addr == addr_d[irq_vec]));

    a_r8_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (LVL_W'(prio_d[irq_vec]) < lvl_d));

    a_r7_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !irq_ret) |=> (svc_level == LVL_W'($past(prio_d[irq_vec]))));

    a_r9_ret_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && (svc_level != LVL_W'(NUM_LVL))) |=> (svc_level > $past(svc_level)));
endmodule

bind vec_irq_ctrl vic_checker #(
    .NUM_VEC (NUM_VEC),
    .NUM_LVL (NUM_LVL),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .prio      (prio_q),
    .haddr     (haddr_q),
    .pend      (pend_q),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_addr  (irq_addr),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .svc_level (svc_level)
);

// File: tb/vec_irq_ctrl_tb_top.sv
// Self-checking bench: per-vector source sweep, enable/software pending,
// pseudo-random arbitration trials and an eight-deep nesting sequence.
module vec_irq_ctrl_tb_top;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_op = '0;
    logic [4:0]    cfg_idx = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [NV-1:0] req_fixed = '0;
    logic [NV-1:0] req_dma = '0;
    logic [NV-1:0] req_route = '0;
    logic          irq_req;
    logic [4:0]    irq_vec;
    logic [15:0]   irq_addr;
    logic          irq_ack = 1'b0;
    logic          irq_ret = 1'b0;
    logic [3:0]    svc_level;

    int n_checks = 0;
    int n_fail = 0;
    int tb_prio [NV];
    logic [31:0] lfsr = 32'h1d2c_3b4a;

    always #2.5 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_fixed(req_fixed),
        .req_dma(req_dma), .req_route(req_route), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_addr(irq_addr), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .svc_level(svc_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int op, input int idx, input int data);
        cfg_we = 1'b1; cfg_op = 3'(op); cfg_idx = 5'(idx); cfg_wdata = 16'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int src, input int v);
        case (src)
            0: req_fixed[v] = 1'b1;
            1: req_dma[v] = 1'b1;
            default: req_route[v] = 1'b1;
        endcase
        tick();
        req_fixed = '0; req_dma = '0; req_route = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    endtask

    function automatic int exp_winner(input logic [31:0] m);
        int best = -1;
        for (int i = 0; i < NV; i++)
            if (m[i] && (best < 0 || tb_prio[i] < tb_prio[best])) best = i;
        return best;
    endfunction

    task automatic run_all();
        logic [31:0] mask;
        int w;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 req after reset", int'(irq_req), 0);
        chk("R1 level after reset", int'(svc_level), 8);
        for (int v = 0; v < NV; v++) begin
            wr(3, v, 16'h1000 + v * 4);
            tb_prio[v] = 7;
        end
        tick();
        chk("R1 nothing pending", int'(irq_req), 0);

        // Per-vector, per-source sweep.
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < 3; s++) begin
                wr(2, v, s);
                wr(0, v, 1);
                pulse((s + 1) % 3, v);
                tick();
                chk("R2 unselected line ignored", int'(irq_req), 0);
                pulse(s, v);
                chk("R10 request one cycle later", int'(irq_req), 0);
                tick();
                chk("R2 selected edge requests", int'(irq_req), 1);
                chk("R4 vector number", int'(irq_vec), v);
                chk("R5 handler address", int'(irq_addr), 16'h1000 + v * 4);
                ack();
                tick();
                chk("R7 level after ack", int'(svc_level), 7);
                chk("R7 pending cleared", int'(irq_req), 0);
                ret();
                chk("R9 level after return", int'(svc_level), 8);
                wr(0, v, 0);
            end
        end

        // Enable and software pending on vector 5.
        wr(2, 5, 0);
        pulse(0, 5);
        tick();
        chk("R3 disabled holds off", int'(irq_req), 0);
        wr(0, 5, 1);
        chk("R10 enable latency", int'(irq_req), 0);
        tick();
        chk("R3 held pending requested", int'(irq_req), 1);
        chk("R3 vector", int'(irq_vec), 5);
        wr(5, 5, 0);
        tick();
        chk("R6 software clear", int'(irq_req), 0);
        wr(4, 5, 0);
        tick();
        chk("R6 software set", int'(irq_req), 1);
        wr(5, 5, 0);
        wr(2, 5, 3);
        pulse(0, 5); pulse(1, 5); pulse(2, 5);
        tick();
        chk("R2 no-source select", int'(irq_req), 0);
        wr(2, 5, 0);

        // Arbitration trials with run-time priority changes.
        for (int v = 0; v < NV; v++) wr(0, v, 1);
        for (int k = 0; k < 40; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            mask = lfsr & (lfsr >> 3);
            if (mask == 0) mask = 32'h8000_0001;
            for (int v = 0; v < NV; v++) begin
                tb_prio[v] = (v * 5 + k) % 8;
                wr(1, v, tb_prio[v]);
                wr(5, v, 0);
            end
            for (int v = 0; v < NV; v++) if (mask[v]) wr(4, v, 0);
            tick();
            w = exp_winner(mask);
            chk("R4 arbitration winner", int'(irq_vec), w);
            chk("R4 request present", int'(irq_req), 1);
            tb_prio[w] = 7;
            wr(1, w, 7);
            tick();
            chk("R11 winner after priority rewrite", int'(irq_vec), exp_winner(mask));
        end
        for (int v = 0; v < NV; v++) begin
            wr(0, v, 0);
            wr(5, v, 0);
        end

        // Eight-deep nesting, strict preemption, then unwinding.
        for (int v = 0; v < 8; v++) begin
            wr(1, v, 7 - v);
            wr(0, v, 1);
        end
        wr(1, 8, 0); wr(0, 8, 1);
        wr(1, 9, 3); wr(0, 9, 1);
        for (int v = 0; v < 8; v++) begin
            wr(4, v, 0);
            tick();
            chk("R8 better priority preempts", int'(irq_req), 1);
            chk("R8 preempting vector", int'(irq_vec), v);
            ack();
            tick();
            chk("R7 nested level", int'(svc_level), 7 - v);
        end
        wr(4, 8, 0);
        wr(4, 9, 0);
        tick();
        chk("R8 equal priority does not preempt", int'(irq_req), 0);
        wr(5, 8, 0);
        wr(5, 9, 0);
        for (int k = 1; k <= 8; k++) begin
            ret();
            chk("R9 unwound level", int'(svc_level), k);
        end
        tick();
        chk("R9 idle after unwinding", int'(irq_req), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule